// File: doc/BRIEF.md
# SD Host Software Reset Controller

This block holds the byte-wide software reset control register of an SD/eMMC host controller and turns its bits into clear strobes for three reset domains: the data path, the command path and the whole controller. Software writes the register through a simple write port; the block decodes its own offset and drives per-domain clear strobes into a compact model of the host's present-state flags, block-gap requests, interrupt status bits, buffer data port word and capabilities control register.

The data-path and command-path resets act for a single cycle and clear themselves. The full reset stays active until a capabilities-valid input pulses. Its clear is held on every cycle until then. It spares the live line levels and card-detection flags, and it spares the key field of the capabilities control register.

Top module: `sdh_swrst_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and `status_o`, `dport_o` and `capc_o` are all zero.
- R2: A write at `REG_OFFSET` with data bit 2 set starts the data-path reset. The bit reads 1 for one cycle and then 0. `dat_clr_o` and `dma_rst_o` are high during that cycle. At the following edge, status bits 0-5 and 7-13 (mask 0x3FBF) and `dport_o` clear.
- R3: A write with data bit 1 set starts the command-path reset. The bit reads 1 for one cycle and then 0. Only status bits 6 and 14 (mask 0x4040) clear, and `dport_o` keeps its value.
- R4: A write with data bit 0 set starts the full reset. It clears status bits 0-14 and 21 (mask 0x207FFF), `dport_o`, and the low `CAP_W-KEY_W` bits of `capc_o`. It keeps status bits 15-20: CMD level, DAT level, write-protect level, card-detect level, card stable and card inserted. It also keeps the top `KEY_W` bits of `capc_o`.
- R5: Register bit 0 stays 1, and the full clear repeats every cycle, until `cap_valid_i` is sampled high. Bit 0 reads 0 after that edge. Bits set through `host_set_i` during the hold do not survive.
- R6: The register encodes the data-path reset at bit 2, the command-path reset at bit 1 and the full reset at bit 0. Bits 7 to 3 always read 0, and 0 is normal operation.
- R7: A write to any address other than `REG_OFFSET` has no effect on the register or the model.
- R8: A write with several reset bits set applies the union of their clear sets. With bit 0 among them, the full reset's superset applies and bits 2 and 1 still self-clear after one cycle.
- R9: Writing 0 to bit 0 while the full reset is pending does not end it. A `cap_valid_i` pulse while no full reset is pending has no effect.
- R10: Within the model, a clear beats a same-cycle set or load from `host_set_i`, `dport_we_i` or `capc_we_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| rdata_o | output | 8 | Readback of the reset register |
| cap_valid_i | input | 1 | Capability registers valid pulse |
| host_set_i | input | 22 | Per-bit set events into the status model |
| status_o | output | 22 | Modelled present-state, block-gap and interrupt bits |
| dport_we_i | input | 1 | Buffer data port load strobe |
| dport_wdata_i | input | DATA_W | Buffer data port load value |
| dport_o | output | DATA_W | Buffer data port word |
| capc_we_i | input | 1 | Capabilities control load strobe |
| capc_wdata_i | input | CAP_W | Capabilities control load value |
| capc_o | output | CAP_W | Capabilities control register |
| dat_clr_o | output | 1 | Data-domain clear strobe |
| cmd_clr_o | output | 1 | Command-domain clear strobe |
| all_clr_o | output | 1 | Full clear strobe |
| dma_rst_o | output | 1 | DMA circuit reset |

## Verification
A register write lands on the clock edge that samples it. The register bit and the clear strobes are visible from that edge until the next one. The cleared model values appear one edge later, so the bench reads the readback and strobes half a cycle after the write edge and the model a full cycle after that. A full-reset release shows one edge after `cap_valid_i` is sampled. The bench drives the pulse a set number of cycles after the request and checks the hold just before it and the release just after it. Inputs change on the falling edge and every comparison is also made on a falling edge, so no check depends on the order of processes at the active edge.

// File: rtl/sdh_swrst_pkg.sv
package sdh_swrst_pkg;

    // Status model bit positions
    localparam int ST_N          = 22;
    localparam int ST_BUF_RD_EN  = 0;
    localparam int ST_BUF_WR_EN  = 1;
    localparam int ST_RD_ACT     = 2;
    localparam int ST_WR_ACT     = 3;
    localparam int ST_DAT_ACT    = 4;
    localparam int ST_DAT_INH    = 5;
    localparam int ST_CMD_INH    = 6;
    localparam int ST_GAP_CONT   = 7;
    localparam int ST_GAP_STOP   = 8;
    localparam int ST_IRQ_RD_RDY = 9;
    localparam int ST_IRQ_WR_RDY = 10;
    localparam int ST_IRQ_DMA    = 11;
    localparam int ST_IRQ_GAP    = 12;
    localparam int ST_IRQ_XFER   = 13;
    localparam int ST_IRQ_CMD    = 14;
    localparam int ST_LVL_CMD    = 15;
    localparam int ST_LVL_DAT    = 16;
    localparam int ST_LVL_WP     = 17;
    localparam int ST_LVL_CD     = 18;
    localparam int ST_CARD_STBL  = 19;
    localparam int ST_CARD_IN    = 20;
    localparam int ST_IRQ_ERR    = 21;

    // Reset register bit positions (decoded by software, so fixed)
    localparam int RB_ALL = 0;
    localparam int RB_CMD = 1;
    localparam int RB_DAT = 2;

    function automatic logic [ST_N-1:0] st_bit(input int idx);
        return ST_N'(1) << idx;
    endfunction

    localparam logic [ST_N-1:0] DAT_MASK =
        st_bit(ST_BUF_RD_EN) | st_bit(ST_BUF_WR_EN) | st_bit(ST_RD_ACT) |
        st_bit(ST_WR_ACT) | st_bit(ST_DAT_ACT) | st_bit(ST_DAT_INH) |
        st_bit(ST_GAP_CONT) | st_bit(ST_GAP_STOP) | st_bit(ST_IRQ_RD_RDY) |
        st_bit(ST_IRQ_WR_RDY) | st_bit(ST_IRQ_DMA) | st_bit(ST_IRQ_GAP) |
        st_bit(ST_IRQ_XFER);

    localparam logic [ST_N-1:0] CMD_MASK = st_bit(ST_CMD_INH) | st_bit(ST_IRQ_CMD);

    localparam logic [ST_N-1:0] KEEP_MASK =
        st_bit(ST_LVL_CMD) | st_bit(ST_LVL_DAT) | st_bit(ST_LVL_WP) |
        st_bit(ST_LVL_CD) | st_bit(ST_CARD_STBL) | st_bit(ST_CARD_IN);

    localparam logic [ST_N-1:0] ALL_MASK = ~KEEP_MASK;

    typedef struct packed {
        logic dat;
        logic cmd;
        logic all;
    } rst_req_t;

endpackage

// File: rtl/sdh_swrst_reg.sv
module sdh_swrst_reg
    import sdh_swrst_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int unsigned REG_OFFSET = 'h2F
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [2:0]        wr_bits_i,
    input  logic              cap_valid_i,
    output rst_req_t          req_o
);

    rst_req_t req_d, req_q;
    logic     hit;

    always_comb begin
        hit       = wr_en_i && (wr_addr_i == ADDR_W'(REG_OFFSET));
        // Partial resets live for exactly one cycle per write.
        req_d.dat = hit && wr_bits_i[RB_DAT];
        req_d.cmd = hit && wr_bits_i[RB_CMD];
        // Full reset is sticky until the capability registers are valid.
        req_d.all = (req_q.all && !cap_valid_i) || (hit && wr_bits_i[RB_ALL]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= '0;
        else         req_q <= req_d;
    end

    assign req_o = req_q;

endmodule

// File: rtl/sdh_swrst_fanout.sv
module sdh_swrst_fanout
    import sdh_swrst_pkg::*;
(
    input  rst_req_t        req_i,
    output logic            dat_clr_o,
    output logic            cmd_clr_o,
    output logic            all_clr_o,
    output logic [ST_N-1:0] st_clr_o
);

    always_comb begin
        all_clr_o = req_i.all;
        dat_clr_o = req_i.dat || req_i.all;
        cmd_clr_o = req_i.cmd || req_i.all;
        st_clr_o  = '0;
        if (req_i.dat) st_clr_o = st_clr_o | DAT_MASK;
        if (req_i.cmd) st_clr_o = st_clr_o | CMD_MASK;
        if (req_i.all) st_clr_o = st_clr_o | ALL_MASK;
    end

endmodule

// File: rtl/sdh_swrst_state.sv
module sdh_swrst_state
    import sdh_swrst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CAP_W  = 16,
    parameter int KEY_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ST_N-1:0]   set_i,
    input  logic [ST_N-1:0]   clr_i,
    input  logic              dport_we_i,
    input  logic [DATA_W-1:0] dport_wdata_i,
    input  logic              dport_clr_i,
    input  logic              capc_we_i,
    input  logic [CAP_W-1:0]  capc_wdata_i,
    input  logic              capc_clr_i,
    output logic [ST_N-1:0]   status_o,
    output logic [DATA_W-1:0] dport_o,
    output logic [CAP_W-1:0]  capc_o
);

    localparam logic [CAP_W-1:0] KEY_KEEP = CAP_W'({KEY_W{1'b1}}) << (CAP_W - KEY_W);

    typedef struct packed {
        logic [ST_N-1:0]   st;
        logic [DATA_W-1:0] dp;
        logic [CAP_W-1:0]  cc;
    } model_t;

    model_t          mdl_d, mdl_q;
    logic [ST_N-1:0] st_nxt;

    // Per-bit next value: set events OR in, the clear mask wins.
    for (genvar i = 0; i < ST_N; i++) begin : g_st
        assign st_nxt[i] = (mdl_q.st[i] || set_i[i]) && !clr_i[i];
    end

    always_comb begin
        mdl_d    = mdl_q;
        mdl_d.st = st_nxt;
        if (dport_clr_i)     mdl_d.dp = '0;
        else if (dport_we_i) mdl_d.dp = dport_wdata_i;
        if (capc_clr_i)      mdl_d.cc = mdl_q.cc & KEY_KEEP;
        else if (capc_we_i)  mdl_d.cc = capc_wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mdl_q <= '0;
        else         mdl_q <= mdl_d;
    end

    assign status_o = mdl_q.st;
    assign dport_o  = mdl_q.dp;
    assign capc_o   = mdl_q.cc;

endmodule

// File: rtl/sdh_swrst_ctrl.sv
module sdh_swrst_ctrl
    import sdh_swrst_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int unsigned REG_OFFSET = 'h2F,
    parameter int          DATA_W     = 32,
    parameter int          CAP_W      = 16,
    parameter int          KEY_W      = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [7:0]        rdata_o,
    input  logic              cap_valid_i,
    input  logic [ST_N-1:0]   host_set_i,
    output logic [ST_N-1:0]   status_o,
    input  logic              dport_we_i,
    input  logic [DATA_W-1:0] dport_wdata_i,
    output logic [DATA_W-1:0] dport_o,
    input  logic              capc_we_i,
    input  logic [CAP_W-1:0]  capc_wdata_i,
    output logic [CAP_W-1:0]  capc_o,
    output logic              dat_clr_o,
    output logic              cmd_clr_o,
    output logic              all_clr_o,
    output logic              dma_rst_o
);

    rst_req_t        req;
    logic [ST_N-1:0] st_clr;
    logic            unused_wr_hi;

    assign unused_wr_hi = ^wr_data_i[7:3];

    sdh_swrst_reg #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_reg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_bits_i   (wr_data_i[2:0]),
        .cap_valid_i (cap_valid_i),
        .req_o       (req)
    );

    sdh_swrst_fanout u_fan (
        .req_i     (req),
        .dat_clr_o (dat_clr_o),
        .cmd_clr_o (cmd_clr_o),
        .all_clr_o (all_clr_o),
        .st_clr_o  (st_clr)
    );

    sdh_swrst_state #(
        .DATA_W (DATA_W),
        .CAP_W  (CAP_W),
        .KEY_W  (KEY_W)
    ) u_state (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .set_i         (host_set_i),
        .clr_i         (st_clr),
        .dport_we_i    (dport_we_i),
        .dport_wdata_i (dport_wdata_i),
        .dport_clr_i   (dat_clr_o),
        .capc_we_i     (capc_we_i),
        .capc_wdata_i  (capc_wdata_i),
        .capc_clr_i    (all_clr_o),
        .status_o      (status_o),
        .dport_o       (dport_o),
        .capc_o        (capc_o)
    );

    assign dma_rst_o = dat_clr_o;

    always_comb begin
        rdata_o         = '0;
        rdata_o[RB_DAT] = req.dat;
        rdata_o[RB_CMD] = req.cmd;
        rdata_o[RB_ALL] = req.all;
    end

endmodule

// File: rtl/sdh_swrst_chk.sv
module sdh_swrst_chk
    import sdh_swrst_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int unsigned REG_OFFSET = 'h2F
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [7:0]        wr_data_i,
    input logic [7:0]        rdata_o,
    input logic              cap_valid_i,
    input logic [ST_N-1:0]   host_set_i,
    input logic [ST_N-1:0]   status_o,
    input logic              dat_clr_o,
    input logic              cmd_clr_o,
    input logic              all_clr_o
);

    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_W'(REG_OFFSET));

    AST_DAT_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o[2] && !(hit && wr_data_i[2])) |=> !rdata_o[2]);  // R2
    AST_DAT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dat_clr_o |=> ((status_o & DAT_MASK) == '0));  // R2
    AST_CMD_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o[1] && !(hit && wr_data_i[1])) |=> !rdata_o[1]);  // R3
    AST_CMD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_clr_o |=> ((status_o & CMD_MASK) == '0));  // R3
    AST_ALL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        all_clr_o |=> ((status_o & ALL_MASK) == '0));  // R4
    AST_ALL_KEEPS_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (all_clr_o && ((host_set_i & KEEP_MASK) == '0)) |=> $stable(status_o & KEEP_MASK));  // R4
    AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o[0] && !cap_valid_i) |=> rdata_o[0]);  // R5
    AST_FULL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rdata_o[0] && cap_valid_i && !(hit && wr_data_i[0])) |=> !rdata_o[0]);  // R5
    AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rdata_o[7:3] == 5'd0);  // R6
    AST_NO_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hit && !rdata_o[0] && !(rdata_o[0] && !cap_valid_i)) |=> (rdata_o == 8'd0));  // R7

endmodule

bind sdh_swrst_ctrl sdh_swrst_chk #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rdata_o     (rdata_o),
    .cap_valid_i (cap_valid_i),
    .host_set_i  (host_set_i),
    .status_o    (status_o),
    .dat_clr_o   (dat_clr_o),
    .cmd_clr_o   (cmd_clr_o),
    .all_clr_o   (all_clr_o)
);

// File: tb/sdh_swrst_ctrl_bench.sv
module sdh_swrst_ctrl_bench;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int CAP_W    = 16;
    localparam int KEY_W    = 8;
    localparam int NST      = 22;
    localparam int CAPV_DLY = 6;
    localparam logic [7:0] OFF = 8'h2F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [7:0]        rdata;
    logic              cap_valid = 1'b0;
    logic [NST-1:0]    host_set = '0;
    logic [NST-1:0]    status;
    logic              dport_we = 1'b0;
    logic [DATA_W-1:0] dport_wdata = '0;
    logic [DATA_W-1:0] dport;
    logic              capc_we = 1'b0;
    logic [CAP_W-1:0]  capc_wdata = '0;
    logic [CAP_W-1:0]  capc;
    logic              dat_clr, cmd_clr, all_clr, dma_rst;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    sdh_swrst_ctrl #(
        .ADDR_W (ADDR_W), .REG_OFFSET ('h2F), .DATA_W (DATA_W),
        .CAP_W (CAP_W), .KEY_W (KEY_W)
    ) u_sdh_swrst_ctrl (
        .clk_i (clk), .rst_ni (rst_n),
        .wr_en_i (wr_en), .wr_addr_i (wr_addr), .wr_data_i (wr_data),
        .rdata_o (rdata), .cap_valid_i (cap_valid),
        .host_set_i (host_set), .status_o (status),
        .dport_we_i (dport_we), .dport_wdata_i (dport_wdata), .dport_o (dport),
        .capc_we_i (capc_we), .capc_wdata_i (capc_wdata), .capc_o (capc),
        .dat_clr_o (dat_clr), .cmd_clr_o (cmd_clr), .all_clr_o (all_clr),
        .dma_rst_o (dma_rst)
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
        end
    endtask

    // Write returns on the falling edge after the sampling edge.
    task automatic reg_write(input logic [7:0] addr, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic preload_all();
        @(negedge clk);
        host_set = '1; dport_we = 1'b1; dport_wdata = '1;
        capc_we = 1'b1; capc_wdata = '1;
        @(negedge clk);
        host_set = '0; dport_we = 1'b0; capc_we = 1'b0;
    endtask

    task automatic pulse_set(input logic [NST-1:0] v);
        @(negedge clk);
        host_set = v;
        @(negedge clk);
        host_set = '0;
    endtask

    task automatic release_full();
        @(negedge clk);
        cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R1 rdata", rdata, 8'h00);
        check("R1 status", status, 0);
        check("R1 dport", dport, 0);
        check("R1 capc", capc, 0);
    endtask

    task automatic t_dat_reset();
        preload_all();
        check("R10 preload status", status, 22'h3FFFFF);
        reg_write(OFF, 8'h04);
        check("R6 dat bit position", rdata, 8'h04);
        check("R2 dat_clr strobe", dat_clr, 1);
        check("R2 dma_rst strobe", dma_rst, 1);
        check("R2 cmd_clr quiet", cmd_clr, 0);
        @(negedge clk);
        check("R2 status after dat reset", status, 22'h3FC040);
        check("R2 dport cleared", dport, 0);
        check("R2 capc kept", capc, 16'hFFFF);
        check("R2 self clear", rdata, 8'h00);
        check("R2 dma_rst ends", dma_rst, 0);
    endtask

    task automatic t_cmd_reset();
        preload_all();
        reg_write(OFF, 8'h02);
        check("R6 cmd bit position", rdata, 8'h02);
        check("R3 cmd_clr strobe", cmd_clr, 1);
        check("R3 dat_clr quiet", dat_clr, 0);
        @(negedge clk);
        check("R3 status after cmd reset", status, 22'h3FBFBF);
        check("R3 dport kept", dport, 32'hFFFF_FFFF);
        check("R3 self clear", rdata, 8'h00);
    endtask

    task automatic t_wrong_addr();
        preload_all();
        reg_write(OFF - 8'h01, 8'h07);
        check("R7 rdata after stray write", rdata, 8'h00);
        reg_write(OFF + 8'h01, 8'h07);
        @(negedge clk);
        check("R7 status untouched", status, 22'h3FFFFF);
        check("R7 dport untouched", dport, 32'hFFFF_FFFF);
    endtask

    task automatic t_upper_bits();
        reg_write(OFF, 8'hF8);
        check("R6 upper bits read 0", rdata, 8'h00);
        check("R6 no strobe from upper bits", {dat_clr, cmd_clr, all_clr}, 3'b000);
    endtask

    task automatic t_full_reset();
        preload_all();
        reg_write(OFF, 8'h01);
        check("R6 full bit position", rdata, 8'h01);
        check("R4 all_clr strobe", all_clr, 1);
        @(negedge clk);
        check("R4 status keeps levels", status, 22'h1F8000);
        check("R4 dport cleared", dport, 0);
        check("R4 capc keeps key", capc, 16'hFF00);
        reg_write(OFF, 8'h00);
        check("R9 write 0 does not end full reset", rdata, 8'h01);
        pulse_set('1);
        check("R5 set during hold discarded", status, 22'h1F8000);
        @(negedge clk);
        capc_we = 1'b1; capc_wdata = 16'h00FF;
        @(negedge clk);
        capc_we = 1'b0;
        check("R10 capc load loses to clear", capc, 16'hFF00);
        repeat (CAPV_DLY - 5) @(negedge clk);
        check("R5 held before cap valid", rdata, 8'h01);
        release_full();
        check("R5 released after cap valid", rdata, 8'h00);
        check("R5 all_clr ends", all_clr, 0);
        pulse_set(22'h000001);
        check("R5 sets work after release", status, 22'h1F8001);
    endtask

    task automatic t_capv_idle();
        preload_all();
        release_full();
        check("R9 idle cap valid rdata", rdata, 8'h00);
        check("R9 idle cap valid status", status, 22'h3FFFFF);
    endtask

    task automatic t_combined();
        preload_all();
        reg_write(OFF, 8'h06);
        check("R8 dat+cmd both set", rdata, 8'h06);
        @(negedge clk);
        check("R8 union of clears", status, 22'h3F8000);
        check("R8 both self clear", rdata, 8'h00);
        preload_all();
        reg_write(OFF, 8'h07);
        check("R8 all three set", rdata, 8'h07);
        @(negedge clk);
        check("R8 partial bits clear, full stays", rdata, 8'h01);
        check("R8 superset applies", status, 22'h1F8000);
        repeat (CAPV_DLY - 2) @(negedge clk);
        release_full();
        check("R8 full released", rdata, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_dat_reset();
        t_cmd_reset();
        t_wrong_addr();
        t_upper_bits();
        t_full_reset();
        t_capv_idle();
        t_combined();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule